// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves W-bit data between two ports, A and B, in either direction. Each direction owns a holding register that is loaded by its own capture strobe. It also owns a source select that picks between the live data arriving from the opposite port and the contents of that holding register. The block is meant to sit between two shared buses, where it can act as a pass-through buffer, a snapshot register or an I/O port latch.

Both ports are modelled as separate input, output and output-enable vectors, so the block stays fully synchronous and contains no tristate logic. Every output is registered on the single block clock `clk`. Two enable controls give four operating modes: drive B only, drive A only, drive both ports, or isolate both ports. An isolated port still acts as an input and can feed the holding register of the opposite direction. When a source select changes on the same edge as a load of that direction's register, the output register holds its value for one cycle. This keeps an intermediate value off the port during the changeover. A parameter makes every data output carry the bitwise complement of its source.

Top module: `bxr_xcvr`

## Requirements
- R1: While `rst_n` is low at a rising edge, both holding registers, both data outputs and both output enables become zero. After reset, selecting stored data therefore shows 0.
- R2: A rising edge with `ld_ab` high stores `a_in` into the A-to-B holding register. With `ld_ab` low, that register keeps its value whatever `a_in` does.
- R3: A rising edge with `ld_ba` high stores `b_in` into the B-to-A holding register. With `ld_ba` low, that register keeps its value whatever `b_in` does.
- R4: With `sel_ab` low (live data) and no hold, `b_out` after an edge equals the `a_in` sampled at that edge.
- R5: With `sel_ab` high (stored data) and no hold, `b_out` after an edge equals the A-to-B register contents held just before that edge.
- R6: The A side behaves the same way. With `sel_ba` low, `a_out` follows `b_in`. With `sel_ba` high, it shows the B-to-A register contents held before the edge.
- R7: When a direction's select differs from its value at the previous edge and that direction's load strobe is high, the output of that direction keeps its previous value for that one edge. At the next edge it shows the newly selected source.
- R8: `b_oe` equals `en_ab` (active high) as sampled at the previous edge. `a_oe` equals the inverse of `en_ba_n` (active low) as sampled at the previous edge.
- R9: With `en_ab` low and `en_ba_n` high, both output enables are low. Both holding registers can still load in the same edge from their respective inputs, and the stored values can later be driven onto both ports together.
- R10: With `INVERT` = 1, each data output is the bitwise complement of the value R4 to R7 give. With `INVERT` = 0 (the default), data passes unchanged. Outputs are zero in reset in both cases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | W | Data arriving on port A |
| b_in | input | W | Data arriving on port B |
| ld_ab | input | 1 | Capture strobe for the A-to-B holding register |
| ld_ba | input | 1 | Capture strobe for the B-to-A holding register |
| sel_ab | input | 1 | B output source: 0 live A data, 1 stored A-to-B data |
| sel_ba | input | 1 | A output source: 0 live B data, 1 stored B-to-A data |
| en_ab | input | 1 | Drive enable for port B, active high |
| en_ba_n | input | 1 | Drive enable for port A, active low |
| a_out | output | W | Data driven onto port A |
| a_oe | output | 1 | Port A output enable |
| b_out | output | W | Data driven onto port B |
| b_oe | output | 1 | Port B output enable |

## Verification
Two functions can fall in the same cycle. The first is a change of source select together with a load of the same direction's register. The bench provokes this by flipping `sel_ab`, and later `sel_ba`, on the edge where the matching strobe loads a new value. It expects the output to keep its old value for exactly that edge and to show the newly selected source on the following edge. The second collision is both holding registers loading on one edge while both ports are isolated and both selects are low. The bench judges this by selecting stored data afterwards and checking that each direction holds its own port's data.

// File: rtl/bxr_pkg.sv
package bxr_pkg;

  // Bit 1: port A driven, bit 0: port B driven.
  typedef enum logic [1:0] {
    MODE_ISOLATE = 2'b00,
    MODE_TO_B    = 2'b01,
    MODE_TO_A    = 2'b10,
    MODE_BOTH    = 2'b11
  } mode_t;

  function automatic mode_t decode_mode(input logic en_ab, input logic en_ba_n);
    return mode_t'({~en_ba_n, en_ab});
  endfunction

  function automatic logic drives_a(input mode_t m);
    return (m == MODE_TO_A) || (m == MODE_BOTH);
  endfunction

  function automatic logic drives_b(input mode_t m);
    return (m == MODE_TO_B) || (m == MODE_BOTH);
  endfunction

endpackage

// File: rtl/bxr_store.sv
module bxr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (ld) begin
      q <= d;
    end
  end

endmodule

// File: rtl/bxr_path.sv
module bxr_path #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         ld,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] out,
  output logic         hold
);

  logic         sel_q;
  logic [W-1:0] out_q;
  logic [W-1:0] next_val;

  function automatic logic [W-1:0] pick_src(input logic s,
                                            input logic [W-1:0] lv,
                                            input logic [W-1:0] st);
    return s ? st : lv;
  endfunction

  function automatic logic [W-1:0] polarize(input logic [W-1:0] v);
    return INVERT ? ~v : v;
  endfunction

  // A select change that lands on a load edge freezes the output for that edge.
  assign hold     = ld & (sel ^ sel_q);
  assign next_val = polarize(pick_src(sel, live, stored));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      out_q <= '0;
    end else begin
      sel_q <= sel;
      if (!hold) begin
        out_q <= next_val;
      end
    end
  end

  assign out = out_q;

endmodule

// File: rtl/bxr_mode_dec.sv
module bxr_mode_dec
  import bxr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_ab,
  input  logic  en_ba_n,
  output mode_t mode,
  output logic  a_oe,
  output logic  b_oe
);

  assign mode = decode_mode(en_ab, en_ba_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_oe <= 1'b0;
      b_oe <= 1'b0;
    end else begin
      a_oe <= drives_a(mode);
      b_oe <= drives_b(mode);
    end
  end

endmodule

// File: rtl/bxr_xcvr.sv
module bxr_xcvr
  import bxr_pkg::*;
#(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ld_ab,
  input  logic         ld_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         en_ab,
  input  logic         en_ba_n,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);

  // Named internal events, visible to the bound checker.
  logic [W-1:0] store_ab;
  logic [W-1:0] store_ba;
  logic         hold_ab;
  logic         hold_ba;
  mode_t        mode;

  bxr_store #(.W(W)) u_store_ab (
    .clk(clk), .rst_n(rst_n), .ld(ld_ab), .d(a_in), .q(store_ab)
  );

  bxr_store #(.W(W)) u_store_ba (
    .clk(clk), .rst_n(rst_n), .ld(ld_ba), .d(b_in), .q(store_ba)
  );

  bxr_path #(.W(W), .INVERT(INVERT)) u_path_b (
    .clk(clk), .rst_n(rst_n), .sel(sel_ab), .ld(ld_ab),
    .live(a_in), .stored(store_ab), .out(b_out), .hold(hold_ab)
  );

  bxr_path #(.W(W), .INVERT(INVERT)) u_path_a (
    .clk(clk), .rst_n(rst_n), .sel(sel_ba), .ld(ld_ba),
    .live(b_in), .stored(store_ba), .out(a_out), .hold(hold_ba)
  );

  bxr_mode_dec u_mode (
    .clk(clk), .rst_n(rst_n), .en_ab(en_ab), .en_ba_n(en_ba_n),
    .mode(mode), .a_oe(a_oe), .b_oe(b_oe)
  );

endmodule

// File: rtl/bxr_xcvr_chk.sv
module bxr_xcvr_chk #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         ld_ab,
  input logic         ld_ba,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic         en_ab,
  input logic         en_ba_n,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic [W-1:0] store_ab,
  input logic [W-1:0] store_ba,
  input logic         hold_ab,
  input logic         hold_ba
);

  function automatic logic [W-1:0] flip(input logic [W-1:0] v);
    return INVERT ? ~v : v;
  endfunction

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!a_oe && !b_oe && store_ab == '0 && store_ba == '0 &&
                a_out == '0 && b_out == '0));

  a_r2_capture_ab: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ab |=> store_ab == $past(a_in));

  a_r2_keep_ab: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && !ld_ab |=> $stable(store_ab));

  a_r3_capture_ba: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ba |=> store_ba == $past(b_in));

  a_r4_live_ab: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ab && !hold_ab |=> b_out == flip($past(a_in)));

  a_r5_stored_ab: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ab && !hold_ab |=> b_out == flip($past(store_ab)));

  a_r6_live_ba: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ba && !hold_ba |=> a_out == flip($past(b_in)));

  a_r6_stored_ba: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ba && !hold_ba |=> a_out == flip($past(store_ba)));

  a_r7_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ab |=> $stable(b_out));

  a_r7_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ba |=> $stable(a_out));

  a_r8_b_enable: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> b_oe == $past(en_ab));

  a_r8_a_enable: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> a_oe == !$past(en_ba_n));

  a_r9_isolate: assert property (@(posedge clk) disable iff (!rst_n)
    !en_ab && en_ba_n |=> !a_oe && !b_oe);

endmodule

bind bxr_xcvr bxr_xcvr_chk #(.W(W), .INVERT(INVERT)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
  .ld_ab(ld_ab), .ld_ba(ld_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
  .en_ab(en_ab), .en_ba_n(en_ba_n),
  .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
  .store_ab(store_ab), .store_ba(store_ba),
  .hold_ab(hold_ab), .hold_ba(hold_ba)
);

// File: tb/bxr_xcvr_bench.sv
module bxr_xcvr_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         ld_ab = 1'b0;
  logic         ld_ba = 1'b0;
  logic         sel_ab = 1'b0;
  logic         sel_ba = 1'b0;
  logic         en_ab = 1'b0;
  logic         en_ba_n = 1'b1;
  logic [W-1:0] a_out, b_out, ia_out, ib_out;
  logic         a_oe, b_oe, ia_oe, ib_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bxr_xcvr #(.W(W)) u_bxr_xcvr (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ld_ab(ld_ab), .ld_ba(ld_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .en_ab(en_ab), .en_ba_n(en_ba_n),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  bxr_xcvr #(.W(W), .INVERT(1'b1)) u_inv (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ld_ab(ld_ab), .ld_ba(ld_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .en_ab(en_ab), .en_ba_n(en_ba_n),
    .a_out(ia_out), .a_oe(ia_oe), .b_out(ib_out), .b_oe(ib_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk("R1 b_oe", b_oe, 0);
    chk("R1 a_oe", a_oe, 0);
    chk("R1 b_out", b_out, 0);
    chk("R1 a_out", a_out, 0);
    chk("R10 inv reset", {ia_out, ib_out}, 0);
    rst_n = 1'b1;
    sel_ab = 1'b1; sel_ba = 1'b1;
    tick();
    chk("R1 stored ab zero", b_out, 0);
    chk("R1 stored ba zero", a_out, 0);
    sel_ab = 1'b0; sel_ba = 1'b0;
    tick();
  endtask

  task automatic t_live_ab();
    en_ab = 1'b1; a_in = 8'h3C;
    tick();
    chk("R8 b_oe high", b_oe, 1);
    chk("R8 a_oe low", a_oe, 0);
    chk("R4 live 3C", b_out, 8'h3C);
    chk("R10 inv live", ib_out, 8'hC3);
    a_in = 8'hA5;
    tick();
    chk("R4 live A5", b_out, 8'hA5);
  endtask

  task automatic t_store_ab();
    ld_ab = 1'b1; a_in = 8'h5A;
    tick();
    chk("R4 live during load", b_out, 8'h5A);
    ld_ab = 1'b0; a_in = 8'hFF; sel_ab = 1'b1;
    tick();
    chk("R5 stored 5A", b_out, 8'h5A);
    a_in = 8'h00;
    tick();
    chk("R2 no load keeps 5A", b_out, 8'h5A);
    chk("R10 inv stored", ib_out, 8'hA5);
  endtask

  task automatic t_ba();
    en_ba_n = 1'b0; b_in = 8'hC3;
    tick();
    chk("R8 a_oe high", a_oe, 1);
    chk("R6 live C3", a_out, 8'hC3);
    ld_ba = 1'b1; b_in = 8'h96;
    tick();
    chk("R6 live 96", a_out, 8'h96);
    ld_ba = 1'b0; sel_ba = 1'b1; b_in = 8'h11;
    tick();
    chk("R6 stored 96", a_out, 8'h96);
    b_in = 8'h22;
    tick();
    chk("R3 no load keeps 96", a_out, 8'h96);
  endtask

  task automatic t_glitch();
    sel_ab = 1'b0; ld_ab = 1'b1; a_in = 8'h77;
    tick();
    chk("R7 b hold on select+load", b_out, 8'h5A);
    ld_ab = 1'b0; a_in = 8'h88;
    tick();
    chk("R7 b new source after hold", b_out, 8'h88);
    sel_ab = 1'b1;
    tick();
    chk("R2 loaded 77 during hold", b_out, 8'h77);
    sel_ba = 1'b0; ld_ba = 1'b1; b_in = 8'h44;
    tick();
    chk("R7 a hold on select+load", a_out, 8'h96);
    ld_ba = 1'b0;
    tick();
    chk("R7 a new source after hold", a_out, 8'h44);
  endtask

  task automatic t_isolate();
    en_ab = 1'b0; en_ba_n = 1'b1; sel_ab = 1'b0;
    tick();
    chk("R9 b isolated", b_oe, 0);
    chk("R9 a isolated", a_oe, 0);
    ld_ab = 1'b1; ld_ba = 1'b1; a_in = 8'hE1; b_in = 8'h1E;
    tick();
    ld_ab = 1'b0; ld_ba = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1;
    a_in = 8'h00; b_in = 8'h00;
    tick();
    chk("R9 ab captured while isolated", b_out, 8'hE1);
    chk("R9 ba captured while isolated", a_out, 8'h1E);
    en_ab = 1'b1; en_ba_n = 1'b0;
    tick();
    chk("R9 both driven", {a_oe, b_oe}, 2'b11);
    chk("R9 stored on B", b_out, 8'hE1);
    chk("R9 stored on A", a_out, 8'h1E);
  endtask

  task automatic t_reset_again();
    rst_n = 1'b0;
    tick();
    chk("R1 mid reset enables", {a_oe, b_oe}, 0);
    chk("R1 mid reset data", {a_out, b_out}, 0);
  endtask

  initial begin
    t_reset();
    t_live_ab();
    t_store_ab();
    t_ba();
    t_glitch();
    t_isolate();
    t_reset_again();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule